// File: doc/BRIEF.md
# Shared-Cache Utility Monitor and Way Split Selector

This block observes the access streams of two cores that share a 16-way cache and decides how many ways each core should own. For each core it keeps a small shadow tag directory covering one set in every 32, kept in exact least-recently-used order. Every shadow hit bumps a counter for the recency depth at which the tag was found. Because LRU is a stack algorithm, the running sum of the first n depth counters predicts how many hits that core would get if it owned n ways.

When the interval tick arrives, a sequential selector takes a snapshot of both counter sets and walks every legal split. It reports the way count for core 0 whose predicted total hits are largest. Core 1 receives the rest. The replacement logic that enforces the split reads `wayAlloc` and treats the one-cycle `allocDone` pulse as the moment of change. After each decision the counters are halved, so older behaviour still counts but weighs less.

Top module: `umon_partition_top`

## Requirements
- R1: During and directly after reset, `wayAlloc` equals 8 and `allocDone` is 0.
- R2: An access is tracked only when the low 5 bits of its set index are zero; accesses to any other set change no counter and no shadow entry.
- R3: Recency position 0 is most recent and 15 least recent. A shadow hit at position p adds one to that core's counter p, and the tag then moves to position 0, pushing the entries that were above it down by one.
- R4: A shadow miss writes the tag at position 0, shifts every entry down by one and discards the entry at position 15; a later access to the discarded tag is a miss.
- R5: The selector returns the core-0 way count a that maximises (sum of core-0 counters 0..a-1) + (sum of core-1 counters 0..15-a).
- R6: The allocation always lies in 1..15, so each core keeps at least one way.
- R7: When several values of a reach the same best total, the smallest a is returned; with all counters zero the result is 1.
- R8: A hit counter that is at its maximum value stays there on further hits.
- R9: In the cycle the new allocation is published, every counter of both cores is replaced by half its value, rounded down.
- R10: `wayAlloc` keeps its previous value until the selection ends. It changes only in the cycle in which `allocDone` is high, and `allocDone` is high for exactly one cycle.
- R11: A tick that arrives while a selection is in progress is ignored; each accepted tick produces exactly one `allocDone` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 2 | Per-core access valid, bit c for core c |
| accSet | input | 2 x SET_BITS | Per-core set index |
| accTag | input | 2 x TAG_BITS | Per-core tag |
| intervalTick | input | 1 | Starts a repartition when the selector is idle |
| wayAlloc | output | clog2(WAYS) | Ways given to core 0 |
| allocDone | output | 1 | One-cycle pulse when a new allocation is published |

## Verification
Counter saturation and halving are the hardest cases to reach, because the counters are invisible at the ports and can only be seen through the split they produce. The bench builds exact hit depths by replaying fixed tag rotations. Rotating among k tags produces a hit at depth k-1 on every access after the first k. These rotations are sized so that a wrapping counter, or one that is not halved, would pick a different split than a correct one. Pseudo-random traffic over a few sampled and unsampled sets, using more tags than the cache has ways, is then compared against an arithmetic model of the stacks and counters.

// File: rtl/umon_pkg.sv
package umon_pkg;

  // Strobes from the selector control to the datapaths
  typedef struct packed {
    logic snap;      // capture counters, clear accumulators
    logic sumStep;   // accumulate core-1 prefix
    logic evalStep;  // score one candidate split
    logic commit;    // publish best split
    logic halve;     // age both counter sets
  } selStrobe_t;

endpackage

// File: rtl/umon_shadow_dir.sv
module umon_shadow_dir #(
  parameter int WAYS         = 16,
  parameter int SET_BITS     = 8,
  parameter int TAG_BITS     = 10,
  parameter int SAMPLE_SHIFT = 5,
  parameter int CNT_BITS     = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             accValid,
  input  logic [SET_BITS-1:0]              accSet,
  input  logic [TAG_BITS-1:0]              accTag,
  input  logic                             halve,
  output logic [WAYS-1:0][CNT_BITS-1:0]    hitCnt
);
  localparam int POS_BITS     = $clog2(WAYS);
  localparam int SAMPLED_BITS = SET_BITS - SAMPLE_SHIFT;
  localparam int NSETS        = 1 << SAMPLED_BITS;
  localparam logic [CNT_BITS-1:0] CNT_MAX = '1;

  logic [WAYS-1:0][TAG_BITS-1:0] tagMem [NSETS];
  logic [NSETS-1:0][WAYS-1:0]    vldMem;

  logic                          sampled;
  logic [SAMPLED_BITS-1:0]       sIdx;
  logic [WAYS-1:0][TAG_BITS-1:0] rowTag, newTag;
  logic [WAYS-1:0]               rowVld, newVld;
  logic                          hitAny;
  logic [POS_BITS-1:0]           hitPos, shiftLimit;

  assign sampled = accValid && (accSet[SAMPLE_SHIFT-1:0] == '0);
  assign sIdx    = accSet[SET_BITS-1:SAMPLE_SHIFT];
  assign rowTag  = tagMem[sIdx];
  assign rowVld  = vldMem[sIdx];

  // Lowest matching depth wins
  always_comb begin
    hitAny = 1'b0;
    hitPos = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (rowVld[w] && (rowTag[w] == accTag)) begin
        hitAny = 1'b1;
        hitPos = POS_BITS'(w);
      end
    end
  end

  assign shiftLimit = hitAny ? hitPos : POS_BITS'(WAYS - 1);

  // New recency order: accessed tag on top, entries down to the limit slide by one
  always_comb begin
    newTag[0] = accTag;
    newVld[0] = 1'b1;
    for (int w = 1; w < WAYS; w++) begin
      if (POS_BITS'(w) <= shiftLimit) begin
        newTag[w] = rowTag[w-1];
        newVld[w] = rowVld[w-1];
      end else begin
        newTag[w] = rowTag[w];
        newVld[w] = rowVld[w];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (sampled) tagMem[sIdx] <= newTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        vldMem <= '0;
    else if (sampled) vldMem[sIdx] <= newVld;
  end

  // One saturating counter per recency depth
  for (genvar g = 0; g < WAYS; g++) begin : gCnt
    logic                incHere;
    logic [CNT_BITS-1:0] cntNext;
    assign incHere = sampled && hitAny && (hitPos == POS_BITS'(g));
    assign cntNext = (incHere && (hitCnt[g] != CNT_MAX)) ? hitCnt[g] + 1'b1 : hitCnt[g];
    always_ff @(posedge clk) begin
      if (!rstN)      hitCnt[g] <= '0;
      else if (halve) hitCnt[g] <= cntNext >> 1;
      else            hitCnt[g] <= cntNext;
    end
  end

endmodule

// File: rtl/umon_select_ctrl.sv
module umon_select_ctrl
  import umon_pkg::*;
#(
  parameter int WAYS = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     intervalTick,
  output selStrobe_t               strobe,
  output logic [$clog2(WAYS)-1:0]  stepIdx,
  output logic                     busy,
  output logic                     allocDone
);
  localparam int POS_BITS = $clog2(WAYS);

  typedef enum logic [1:0] { ST_IDLE, ST_SUM, ST_EVAL, ST_FIN } selState_t;
  selState_t state;

  always_comb begin
    strobe          = '0;
    strobe.snap     = (state == ST_IDLE) && intervalTick;
    strobe.sumStep  = (state == ST_SUM);
    strobe.evalStep = (state == ST_EVAL);
    strobe.commit   = (state == ST_FIN);
    strobe.halve    = (state == ST_FIN);
  end

  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stepIdx   <= '0;
      allocDone <= 1'b0;
    end else begin
      allocDone <= (state == ST_FIN);
      unique case (state)
        ST_IDLE: if (intervalTick) begin
          state   <= ST_SUM;
          stepIdx <= '0;
        end
        ST_SUM: begin
          if (stepIdx == POS_BITS'(WAYS - 2)) begin
            state   <= ST_EVAL;
            stepIdx <= POS_BITS'(1);
          end else begin
            stepIdx <= stepIdx + 1'b1;
          end
        end
        ST_EVAL: begin
          if (stepIdx == POS_BITS'(WAYS - 1)) state <= ST_FIN;
          else stepIdx <= stepIdx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/umon_select_dp.sv
module umon_select_dp
  import umon_pkg::*;
#(
  parameter int WAYS     = 16,
  parameter int CNT_BITS = 16
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  selStrobe_t                          strobe,
  input  logic [$clog2(WAYS)-1:0]             stepIdx,
  input  logic [WAYS-1:0][CNT_BITS-1:0]       cntCore0,
  input  logic [WAYS-1:0][CNT_BITS-1:0]       cntCore1,
  output logic [$clog2(WAYS)-1:0]             wayAlloc
);
  localparam int POS_BITS   = $clog2(WAYS);
  localparam int SUM_BITS   = CNT_BITS + POS_BITS + 1;
  localparam int SCORE_BITS = SUM_BITS + 1;

  logic [WAYS-1:0][CNT_BITS-1:0] snap0, snap1;
  logic [SUM_BITS-1:0]           sum0, sum1;
  logic [SCORE_BITS-1:0]         score, bestScore;
  logic [POS_BITS-1:0]           bestA, mirrorIdx;

  assign score     = SCORE_BITS'(sum0) + SCORE_BITS'(sum1);
  assign mirrorIdx = POS_BITS'(WAYS - 1) - stepIdx;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snap0     <= '0;
      snap1     <= '0;
      sum0      <= '0;
      sum1      <= '0;
      bestScore <= '0;
      bestA     <= POS_BITS'(1);
      wayAlloc  <= POS_BITS'(WAYS / 2);
    end else begin
      if (strobe.snap) begin
        snap0     <= cntCore0;
        snap1     <= cntCore1;
        sum0      <= SUM_BITS'(cntCore0[0]);
        sum1      <= '0;
        bestScore <= '0;
        bestA     <= POS_BITS'(1);
      end
      if (strobe.sumStep) sum1 <= sum1 + SUM_BITS'(snap1[stepIdx]);
      if (strobe.evalStep) begin
        // strict compare keeps the smallest a on ties
        if (score > bestScore) begin
          bestScore <= score;
          bestA     <= stepIdx;
        end
        sum0 <= sum0 + SUM_BITS'(snap0[stepIdx]);
        sum1 <= sum1 - SUM_BITS'(snap1[mirrorIdx]);
      end
      if (strobe.commit) wayAlloc <= bestA;
    end
  end

endmodule

// File: rtl/umon_partition_top.sv
module umon_partition_top
  import umon_pkg::*;
#(
  parameter int WAYS         = 16,
  parameter int SET_BITS     = 8,
  parameter int TAG_BITS     = 10,
  parameter int SAMPLE_SHIFT = 5,
  parameter int CNT_BITS     = 16
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic [1:0]                       accValid,
  input  logic [1:0][SET_BITS-1:0]         accSet,
  input  logic [1:0][TAG_BITS-1:0]         accTag,
  input  logic                             intervalTick,
  output logic [$clog2(WAYS)-1:0]          wayAlloc,
  output logic                             allocDone
);
  localparam int NCORES   = 2;
  localparam int POS_BITS = $clog2(WAYS);

  selStrobe_t                             strobe;
  logic [POS_BITS-1:0]                    stepIdx;
  logic                                   busy;
  logic [NCORES-1:0][WAYS-1:0][CNT_BITS-1:0] hitCnt;

  for (genvar c = 0; c < NCORES; c++) begin : gCore
    umon_shadow_dir #(
      .WAYS(WAYS), .SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS),
      .SAMPLE_SHIFT(SAMPLE_SHIFT), .CNT_BITS(CNT_BITS)
    ) uDir (
      .clk(clk), .rstN(rstN),
      .accValid(accValid[c]), .accSet(accSet[c]), .accTag(accTag[c]),
      .halve(strobe.halve), .hitCnt(hitCnt[c])
    );
  end

  umon_select_ctrl #(.WAYS(WAYS)) uCtrl (
    .clk(clk), .rstN(rstN), .intervalTick(intervalTick),
    .strobe(strobe), .stepIdx(stepIdx), .busy(busy), .allocDone(allocDone)
  );

  umon_select_dp #(.WAYS(WAYS), .CNT_BITS(CNT_BITS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .stepIdx(stepIdx),
    .cntCore0(hitCnt[0]), .cntCore1(hitCnt[1]), .wayAlloc(wayAlloc)
  );

endmodule

// File: rtl/umon_partition_chk.sv
module umon_partition_chk #(
  parameter int WAYS = 16
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    intervalTick,
  input logic                    busy,
  input logic                    allocDone,
  input logic [$clog2(WAYS)-1:0] wayAlloc
);
  localparam int POS_BITS = $clog2(WAYS);

  a_r6_alloc_range: assert property (@(posedge clk) disable iff (!rstN)
    (wayAlloc >= POS_BITS'(1)) && (wayAlloc <= POS_BITS'(WAYS - 1)));

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |=> !allocDone);

  a_r10_alloc_held: assert property (@(posedge clk) disable iff (!rstN)
    !allocDone |-> $stable(wayAlloc));

  a_r10_done_after_walk: assert property (@(posedge clk) disable iff (!rstN)
    allocDone |-> !busy);

  a_r11_tick_starts_walk: assert property (@(posedge clk) disable iff (!rstN)
    (intervalTick && !busy) |=> busy);

endmodule

bind umon_partition_top umon_partition_chk #(.WAYS(WAYS)) uChk (
  .clk(clk), .rstN(rstN), .intervalTick(intervalTick), .busy(busy),
  .allocDone(allocDone), .wayAlloc(wayAlloc)
);

// File: tb/tb_umon_partition_top.sv
module tb_umon_partition_top;
  localparam int CLK_PERIOD = 10;
  localparam int WAYS = 16, SET_BITS = 8, TAG_BITS = 8, SAMPLE_SHIFT = 5, CNT_BITS = 6;
  localparam int NSETS = 1 << (SET_BITS - SAMPLE_SHIFT);
  localparam int CMAX = (1 << CNT_BITS) - 1;

  logic clk = 0, rstN = 0, intervalTick = 0;
  logic [1:0] accValid = '0;
  logic [1:0][SET_BITS-1:0] accSet = '0;
  logic [1:0][TAG_BITS-1:0] accTag = '0;
  logic [3:0] wayAlloc;
  logic allocDone;

  umon_partition_top #(.WAYS(WAYS), .SET_BITS(SET_BITS), .TAG_BITS(TAG_BITS),
    .SAMPLE_SHIFT(SAMPLE_SHIFT), .CNT_BITS(CNT_BITS)) dut (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accSet(accSet), .accTag(accTag),
    .intervalTick(intervalTick), .wayAlloc(wayAlloc), .allocDone(allocDone));

  always #(CLK_PERIOD/2) clk = ~clk;

  int nRun = 0, nFail = 0;
  int mTag [2][NSETS][WAYS];
  bit mVld [2][NSETS][WAYS];
  int mCnt [2][WAYS];
  int doneSeen;
  logic [31:0] rng = 32'h1234_5678;

  always @(posedge clk) if (allocDone) doneSeen++;

  task automatic check(string req, int got, int exp);
    nRun++;
    if (got != exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic modelClear();
    for (int c = 0; c < 2; c++) begin
      for (int w = 0; w < WAYS; w++) mCnt[c][w] = 0;
      for (int s = 0; s < NSETS; s++) for (int w = 0; w < WAYS; w++) mVld[c][s][w] = 0;
    end
  endtask

  task automatic doReset();
    rstN = 0;
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1;
  endtask

  task automatic modelAccess(int c, int setIdx, int tag);
    int s, pos, lim;
    if ((setIdx % 32) != 0) return;
    s = setIdx / 32;
    pos = -1;
    for (int w = 0; w < WAYS; w++) if (pos < 0 && mVld[c][s][w] && mTag[c][s][w] == tag) pos = w;
    if (pos >= 0 && mCnt[c][pos] < CMAX) mCnt[c][pos]++;
    lim = (pos >= 0) ? pos : WAYS - 1;
    for (int w = lim; w > 0; w--) begin
      mTag[c][s][w] = mTag[c][s][w-1];
      mVld[c][s][w] = mVld[c][s][w-1];
    end
    mTag[c][s][0] = tag;
    mVld[c][s][0] = 1;
  endtask

  task automatic doAccess(int c, int setIdx, int tag);
    accValid[c] = 1'b1;
    accSet[c] = SET_BITS'(setIdx);
    accTag[c] = TAG_BITS'(tag);
    @(negedge clk);
    accValid = '0;
    modelAccess(c, setIdx, tag);
  endtask

  // accesses tag base+(k mod n) for k in [k0,k1)
  task automatic rotate(int c, int setIdx, int n, int k0, int k1, int base);
    for (int k = k0; k < k1; k++) doAccess(c, setIdx, base + (k % n));
  endtask

  function automatic int modelBest();
    int best, bestScore, sc;
    best = 1; bestScore = -1;
    for (int a = 1; a < WAYS; a++) begin
      sc = 0;
      for (int i = 0; i < a; i++) sc += mCnt[0][i];
      for (int i = 0; i < WAYS - a; i++) sc += mCnt[1][i];
      if (sc > bestScore) begin bestScore = sc; best = a; end
    end
    return best;
  endfunction

  // Pulses a tick, waits for the result, returns it, ages the model
  task automatic select(output int res);
    int waitCnt;
    doneSeen = 0;
    intervalTick = 1;
    @(negedge clk);
    intervalTick = 0;
    waitCnt = 0;
    while (doneSeen == 0 && waitCnt < 100) begin @(negedge clk); waitCnt++; end
    if (doneSeen == 0) check("R10 done timeout", 0, 1);
    res = int'(wayAlloc);
    for (int c = 0; c < 2; c++) for (int w = 0; w < WAYS; w++) mCnt[c][w] = mCnt[c][w] / 2;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFail++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    int res, prevAlloc;
    modelClear();
    repeat (2) @(negedge clk);
    check("R1 reset alloc", int'(wayAlloc), 8);
    check("R1 reset done", int'(allocDone), 0);
    rstN = 1;
    @(negedge clk);
    check("R1 alloc after reset", int'(wayAlloc), 8);

    // R10/R11: held during walk, second tick ignored, all-zero tie -> 1 (R7)
    doneSeen = 0;
    intervalTick = 1; @(negedge clk); intervalTick = 0;
    repeat (5) @(negedge clk);
    check("R10 held mid-walk", int'(wayAlloc), 8);
    intervalTick = 1; @(negedge clk); intervalTick = 0;
    repeat (80) @(negedge clk);
    check("R11 single done pulse", doneSeen, 1);
    check("R7 all zero", int'(wayAlloc), 1);

    // R2: unsampled set hits must not count
    doReset();
    rotate(0, 64 + 7, 15, 0, 45, 0);
    rotate(0, 1, 15, 0, 45, 0);
    select(res);
    check("R2 unsampled ignored", res, 1);

    // R6: core0 deep demand capped at 15
    doReset();
    rotate(0, 64, 15, 0, 45, 0);
    select(res);
    check("R6 upper bound", res, 15);

    // R3/R4: install shift then hit at depth 14
    doReset();
    for (int t = 0; t < 16; t++) doAccess(0, 0, t);
    doAccess(0, 0, 1);
    select(res);
    check("R4 install shift", res, 15);
    // R4: eviction - 16 tags fill, a 17th evicts tag 100, which then misses
    doReset();
    for (int t = 0; t < 16; t++) doAccess(1, 32, 100 + t);
    doAccess(1, 32, 200);
    doAccess(1, 32, 100);
    for (int t = 0; t < 14; t++) doAccess(1, 32, 100);
    select(res);
    check("R4 evicted tag misses", res, 1);

    // R8: saturation - core0 70 hits at depth 1 vs core1 30 at depth 14
    doReset();
    rotate(0, 0, 2, 0, 72, 0);
    rotate(1, 0, 15, 0, 45, 0);
    select(res);
    check("R8 saturation", res, 2);

    // R9: halving changes the next decision
    doReset();
    rotate(0, 0, 2, 0, 42, 0);
    rotate(1, 0, 15, 0, 45, 0);
    select(res);
    check("R9 before aging", res, 2);
    rotate(1, 0, 15, 45, 51, 0);
    select(res);
    check("R9 after halving", res, 1);

    // R7: equal demand at depth 4 -> smallest of 5..11
    doReset();
    rotate(0, 0, 5, 0, 15, 0);
    rotate(1, 96, 5, 0, 15, 0);
    select(res);
    check("R7 tie smallest", res, 5);

    // R5: interior optimum
    doReset();
    rotate(0, 0, 3, 0, 13, 0);
    rotate(1, 0, 13, 0, 23, 0);
    select(res);
    check("R5 interior split", res, 3);
    prevAlloc = res;
    doneSeen = 0;
    intervalTick = 1; @(negedge clk); intervalTick = 0;
    repeat (10) @(negedge clk);
    check("R10 held second walk", int'(wayAlloc), prevAlloc);
    repeat (40) @(negedge clk);
    for (int c = 0; c < 2; c++) for (int w = 0; w < WAYS; w++) mCnt[c][w] = mCnt[c][w] / 2;

    // R3 R4 R5: pseudo-random traffic against the model
    doReset();
    for (int round = 0; round < 12; round++) begin
      int exp;
      for (int n = 0; n < 400; n++) begin
        int c, s, t;
        rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
        c = int'(rng[0]);
        s = int'(rng[3:1]) * 32 + ((rng[6:4] == 3'd7) ? 3 : 0);
        t = (c == 0) ? int'(rng[15:8] % 8'd20) : int'(rng[15:8] % 8'd18);
        if (round % 3 == 1 && c == 0) t = int'(rng[15:8] % 8'd4);
        doAccess(c, s, t);
      end
      exp = modelBest();
      select(res);
      check("R3 R4 R5 random round", res, exp);
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule